// File: doc/BRIEF.md
# Packed Single-to-Half Precision Rounding Converter

This block narrows a packed vector of IEEE binary32 numbers into IEEE binary16 numbers in one registered step. Each input lane of 32 bits becomes one output lane of 16 bits in the same position, so four lanes give a 64-bit result. The lane count is a parameter that may be 4, 8 or 16. An operation is presented with `in_valid`, and its result, its exception flags and its fault indication appear together one clock later with `out_valid`.

The rounding direction comes from an 8-bit control byte that is given with each operation. Its low two bits pick the mode, and its bit 2 hands the choice to a separate default-mode input instead. Every lane rounds correctly. Values too small for a normal half are delivered as rounded subnormals, even when the flush-to-zero input is raised. Overflow follows the rounding direction. NaNs are quietened with their payload kept. The five exception flags are ORed over all lanes, and a mask vector decides which of them produce a fault.

Top module: `fp32_to_fp16_pack`

## Requirements
- R1: An operation given with `in_valid` high at a rising clock edge gives `out_valid` high after that edge, and `out_valid` is low after any edge where `in_valid` was low. Lane i reads `src[32i+31:32i]` and writes `dst[16i+15:16i]`.
- R2: With mode code 0 (nearest, ties to even), every finite result is the binary16 value nearest the input, and an exact tie goes to the value with an even last mantissa bit.
- R3: Mode code 1 rounds toward minus infinity, code 2 toward plus infinity and code 3 toward zero. The code is taken from `imm[1:0]` when `imm[2]` is 0.
- R4: When `imm[2]` is 1, `imm[1:0]` is ignored and the 2-bit `dflt_rc` input supplies the mode code with the same encoding.
- R5: A result below the smallest normal half (2^-14) is a correctly rounded subnormal or zero. `ftz_en` has no effect on any output.
- R6: A finite input beyond the half range (it rounds to 65536 or more) gives infinity under nearest, under plus-infinity rounding when positive, and under minus-infinity rounding when negative. Otherwise it gives 0x7BFF with the sign in bit 15. Overflow sets flags bit 2 and bit 4.
- R7: A NaN input gives sign, exponent 0x1F, mantissa bit 9 set and mantissa bits 8:0 equal to input bits 21:13. When input bit 22 is 0 (a signalling NaN), flags bit 0 is set.
- R8: Signed zeros and infinities convert exactly, with the sign preserved and no flag set.
- R9: Flags are, by bit: 0 invalid, 1 denormal input, 2 overflow, 3 underflow, 4 inexact. Each is the OR over all lanes of the operation. Inexact means nonzero bits were discarded. Underflow means the exact value is below 2^-14 and is inexact.
- R10: A subnormal input lane sets flags bits 1, 3 and 4 together.
- R11: `xmask` bit n masks flag bit n (1 = masked). `fault` is high exactly when some set flag has its mask bit at 0. With the denormal bit masked and the inexact or underflow bit unmasked, a subnormal input therefore raises `fault`.
- R12: During reset, `out_valid`, `dst`, `flags` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| src | input | 32*LANES | Packed binary32 lanes |
| imm | input | 8 | Control byte: bits 1:0 mode code, bit 2 selects `dflt_rc` |
| dflt_rc | input | 2 | Default mode code |
| ftz_en | input | 1 | Flush-to-zero request; has no effect |
| xmask | input | 5 | Exception mask, one bit per flag |
| out_valid | output | 1 | Result registers hold a new operation |
| dst | output | 16*LANES | Packed binary16 lanes |
| flags | output | 5 | Exception flags ORed over lanes |
| fault | output | 1 | An unmasked exception occurred |

## Verification
The hardest cases to reach are those where rounding carries across a boundary. This happens when the largest subnormal rounds up into the smallest normal, and when the largest finite half rounds into overflow. It also happens when the discarded bits sit exactly at half an ulp, because then the tie rule alone decides the result. Uniform random words almost never land there. The stimulus therefore places chosen encodings such as 2^-25, 65520 and 1 + 2^-11 in separate lanes and repeats them under every mode code. The random vectors draw most exponents from the narrow band around the half range, so that subnormal, normal and overflow lanes mix within one operation.

// File: rtl/fp32_to_fp16_pack.sv
module fp32_to_fp16_pack #(
  parameter int LANES = 4,
  localparam int IW = 32 * LANES,
  localparam int OW = 16 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] src,
  input  logic [7:0]    imm,
  input  logic [1:0]    dflt_rc,
  input  logic          ftz_en,
  input  logic [4:0]    xmask,
  output logic          out_valid,
  output logic [OW-1:0] dst,
  output logic [4:0]    flags,
  output logic          fault
);

  // Result word per lane: {inexact, underflow, overflow, denormal, invalid, half[15:0]}
  function automatic logic [20:0] cvt_lane(input logic [31:0] x, input logic [1:0] rc);
    logic        s, den, up_inf, g, st, inc;
    logic [23:0] sig, q;
    logic [31:0] base, hv;
    logic [14:0] ovf_mag;
    int          ex, sh;
    s       = x[31];
    den     = (x[30:23] == 8'd0);
    up_inf  = (rc == 2'd0) || (rc == 2'd1 && s) || (rc == 2'd2 && !s);
    ovf_mag = up_inf ? 15'h7C00 : 15'h7BFF;
    if (&x[30:23])
      return (x[22:0] == 23'd0) ? {5'b0, s, 15'h7C00}
                                : {4'b0, ~x[22], s, 5'h1F, 1'b1, x[21:13]};
    if (x[30:0] == 31'd0)
      return {5'b0, s, 15'h0000};
    ex = den ? -126 : int'({24'b0, x[30:23]}) - 127;
    if (ex > 15)
      return {5'b10100, s, ovf_mag};
    sig = {~den, x[22:0]};
    sh  = (ex >= -14) ? 13 : -1 - ex;
    if (sh > 26) sh = 26;
    q  = sig >> sh;
    g  = |({8'b0, sig} & (32'd1 << (sh - 1)));
    st = |({8'b0, sig} & ((32'd1 << (sh - 1)) - 32'd1));
    case (rc)
      2'd0:    inc = g & (st | q[0]);
      2'd1:    inc = s & (g | st);
      2'd2:    inc = ~s & (g | st);
      default: inc = 1'b0;
    endcase
    base = (ex >= -14) ? 32'(ex + 14) : 32'd0;
    hv   = (base << 10) + {8'b0, q} + {31'b0, inc};
    if (hv >= 32'h0000_7C00)
      return {5'b10100, s, ovf_mag};
    return {g | st, (ex < -14) && (g | st), 1'b0, den, 1'b0, s, hv[14:0]};
  endfunction

  logic [1:0]    rc_eff;
  logic [20:0]   res [LANES];
  logic [OW-1:0] dst_c;
  logic [4:0]    fl_c;
  logic          unused_ctl;

  assign rc_eff     = imm[2] ? dflt_rc : imm[1:0];
  assign unused_ctl = ^{ftz_en, imm[7:3]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign res[i]              = cvt_lane(src[32*i +: 32], rc_eff);
    assign dst_c[16*i +: 16]   = res[i][15:0];

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (&src[32*i+23 +: 8]) && (|src[32*i +: 23])
      |=> (&dst[16*i+10 +: 5]) && dst[16*i+9]); // R7
    AST_INF_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (src[32*i +: 31] == 31'h7F80_0000)
      |=> dst[16*i +: 16] == {$past(src[32*i+31]), 15'h7C00}); // R8
  end

  always_comb begin
    fl_c = '0;
    for (int i = 0; i < LANES; i++) fl_c |= res[i][20:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flags     <= '0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst   <= dst_c;
        flags <= fl_c;
        fault <= |(fl_c & ~xmask);
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_DENORMAL_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[1] |-> flags[3] && flags[4]); // R10
  AST_OVERFLOW_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[2] |-> flags[4]); // R6
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (&xmask) |=> !fault); // R11

endmodule

// File: tb/test_fp32_to_fp16_pack.sv
module test_fp32_to_fp16_pack;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [32*LN-1:0] src = '0;
  logic [7:0]      imm = '0;
  logic [1:0]      dflt_rc = '0;
  logic            ftz_en = 1'b0;
  logic [4:0]      xmask = '1;
  logic            out_valid;
  logic [16*LN-1:0] dst;
  logic [4:0]      flags;
  logic            fault;

  int tests = 0;
  int fails = 0;

  bit              pend_v = 1'b0;
  logic [16*LN-1:0] pend_d;
  logic [4:0]      pend_f;
  logic            pend_x;
  string           pend_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_to_fp16_pack #(.LANES(LN)) i_fp32_to_fp16_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .imm(imm),
    .dflt_rc(dflt_rc), .ftz_en(ftz_en), .xmask(xmask),
    .out_valid(out_valid), .dst(dst), .flags(flags), .fault(fault));

  function automatic int msb(input logic [95:0] v);
    for (int b = 95; b >= 0; b--) if (v[b]) return b;
    return -1;
  endfunction

  // Reference: exact value in units of 2^-24 carrying 32 fraction bits
  function automatic logic [20:0] ref_lane(input logic [31:0] x, input logic [1:0] rc);
    logic s, de, up_inf, lost, up, inexact, tiny;
    logic [95:0] xf, iv, qv, rem, hlf, mv, sigw;
    int e, ex, t, k, fb, p, h;
    logic [14:0] omag;
    s = x[31];
    e = int'(x[30:23]);
    up_inf = (rc == 0) || (rc == 1 && s) || (rc == 2 && !s);
    omag = up_inf ? 15'h7C00 : 15'h7BFF;
    if (e == 255) begin
      if (x[22:0] == 0) return {5'b0, s, 15'h7C00};
      return {4'b0, ~x[22], s, 5'h1F, 1'b1, x[21:13]};
    end
    if (x[30:0] == 0) return {5'b0, s, 15'h0};
    de = (e == 0);
    ex = de ? -126 : e - 127;
    if (ex > 16) return {5'b10100, s, omag};
    sigw = {72'b0, ~de, x[22:0]};
    t = ex + 33;
    lost = 1'b0;
    if (t >= 0) xf = sigw << t;
    else if (-t >= 24) begin xf = '0; lost = |sigw; end
    else begin
      xf = sigw >> (-t);
      lost = |(sigw & ((96'd1 << (-t)) - 96'd1));
    end
    iv = xf >> 32;
    k = (iv < 2048) ? 0 : msb(iv) - 10;
    fb = 32 + k;
    qv = xf >> fb;
    rem = xf - (qv << fb);
    hlf = 96'd1 << (fb - 1);
    inexact = (rem != 0) || lost;
    case (rc)
      2'd0: up = (rem > hlf) || (rem == hlf && lost) || (rem == hlf && !lost && qv[0]);
      2'd1: up = s && inexact;
      2'd2: up = !s && inexact;
      default: up = 1'b0;
    endcase
    mv = (qv + {95'b0, up}) << k;
    tiny = iv < 1024;
    if (mv < 1024) h = int'(mv);
    else begin
      p = msb(mv);
      h = (p - 10) * 1024 + int'(mv >> (p - 10));
    end
    if (h >= 32'h7C00) return {5'b10100, s, omag};
    return {inexact, tiny && inexact, 1'b0, de, 1'b0, s, h[14:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(pend_v ? pend_tag : "R1", "out_valid", {63'b0, out_valid}, {63'b0, pend_v});
    if (pend_v) begin
      check(pend_tag, "dst", 64'(dst), 64'(pend_d));
      check(pend_tag, "flags", {59'b0, flags}, {59'b0, pend_f});
      check(pend_tag, "fault", {63'b0, fault}, {63'b0, pend_x});
    end
  endtask

  task automatic op(input bit v, input logic [127:0] vec, input logic [7:0] im,
                    input logic [1:0] dr, input logic [4:0] mk, input bit fz, input string tag);
    logic [1:0] rc;
    logic [20:0] r;
    @(negedge clk);
    compare();
    in_valid = v; src = vec; imm = im; dflt_rc = dr; xmask = mk; ftz_en = fz;
    rc = im[2] ? dr : im[1:0];
    pend_v = v;
    pend_tag = tag;
    pend_f = '0;
    for (int i = 0; i < LN; i++) begin
      r = ref_lane(vec[32*i +: 32], rc);
      pend_d[16*i +: 16] = r[15:0];
      pend_f |= r[20:16];
    end
    pend_x = |(pend_f & ~mk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] vr;
    // R12: reset state
    repeat (2) @(negedge clk);
    check("R12", "reset outputs", {out_valid, fault, flags, 41'b0, dst[15:0]}, 64'd0);
    check("R12", "reset dst", 64'(dst), 64'd0);
    rst_n = 1'b1;

    op(1, {32'h4700_0000, 32'h3E80_0000, 32'hC000_0000, 32'h3F80_0000}, 8'h00, 2'd0, 5'h1F, 0, "R1");
    op(0, '0, 8'h00, 2'd0, 5'h1F, 0, "R1");
    op(1, {32'h3300_0000, 32'h387F_C000, 32'h3F80_3000, 32'h3F80_1000}, 8'h00, 2'd0, 5'h1F, 0, "R2");
    op(1, {32'h3880_0000, 32'h387F_F000, 32'h3F80_1001, 32'hBF80_1000}, 8'h00, 2'd0, 5'h1F, 0, "R2");
    for (int m = 1; m < 4; m++) begin
      op(1, {32'hB300_0000, 32'h3300_0000, 32'hBF80_0001, 32'h3F80_0001}, 8'(m), 2'd0, 5'h1F, 0, "R3");
      op(1, {32'hC77F_F000, 32'h387F_F000, 32'hBF80_3000, 32'h3F80_1000}, 8'hF8 | 8'(m), 2'd0, 5'h1F, 0, "R3");
    end
    op(1, {32'hB300_0000, 32'h3300_0000, 32'hBF80_0001, 32'h3F80_0001}, 8'h04, 2'd2, 5'h1F, 0, "R4");
    op(1, {32'hB300_0000, 32'h3300_0000, 32'hBF80_0001, 32'h3F80_0001}, 8'h05, 2'd3, 5'h1F, 0, "R4");
    op(1, {32'hB300_0000, 32'h3300_0000, 32'hBF80_0001, 32'h3F80_0001}, 8'h06, 2'd1, 5'h1F, 0, "R4");
    op(1, {32'h3780_0000, 32'h387F_C000, 32'h3380_0000, 32'h3300_0001}, 8'h00, 2'd0, 5'h1F, 1, "R5");
    op(1, {32'hB780_0001, 32'h3400_0000, 32'h3300_0000, 32'h387F_E000}, 8'h02, 2'd0, 5'h1F, 1, "R5");
    for (int m = 0; m < 4; m++)
      op(1, {32'h477F_E000, 32'h7F7F_FFFF, 32'hC77F_F000, 32'h477F_F000}, 8'(m), 2'd0, 5'h1F, 0, "R6");
    op(1, {32'h7FFF_FFFF, 32'h7F80_0001, 32'hFF81_2345, 32'h7FC0_0001}, 8'h00, 2'd0, 5'h1F, 0, "R7");
    op(1, {32'h7FC0_0000, 32'hFFC0_2000, 32'h7FFF_E000, 32'h7FA0_0000}, 8'h03, 2'd0, 5'h1E, 0, "R7");
    op(1, {32'hFF80_0000, 32'h7F80_0000, 32'h8000_0000, 32'h0000_0000}, 8'h01, 2'd0, 5'h00, 0, "R8");
    op(1, {32'h0000_0000, 32'h0000_0000, 32'h807F_FFFF, 32'h0000_0001}, 8'h02, 2'd0, 5'h0F, 0, "R10");
    op(1, {32'h0000_0000, 32'h3F80_0000, 32'h0040_0000, 32'h0000_0000}, 8'h00, 2'd0, 5'h17, 0, "R10");
    op(1, {32'h3F80_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000}, 8'h00, 2'd0, 5'h1F, 0, "R11");
    op(1, {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0001, 32'h3F80_0000}, 8'h00, 2'd0, 5'h0F, 0, "R11");
    op(1, {32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0001, 32'h3F80_0000}, 8'h00, 2'd0, 5'h1E, 0, "R11");
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < LN; i++) begin
        vr[32*i +: 32] = $urandom;
        if ($urandom_range(0, 3) != 0) vr[32*i+23 +: 8] = 8'(100 + $urandom_range(0, 45));
      end
      op(($urandom_range(0, 7) != 0), vr, 8'($urandom), 2'($urandom), 5'($urandom),
         1'($urandom), "R9");
    end
    op(0, '0, 8'h00, 2'd0, 5'h1F, 0, "R1");
    @(negedge clk);
    compare();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule